// File: doc/BRIEF.md
# Edge-Triggered Timer Capture Unit with Event Prescaler

This block timestamps events on an external input. The input passes through a two-flop synchronizer and is compared with its own previous sample to find rising and falling transitions. A 4-bit mode field selects which transitions count and how many of them make one capture event. On each event the value of a free-running 16-bit timer is copied into a capture register and a sticky interrupt flag is raised. Software clears the flag with a single-cycle strobe.

The mode field both enables capture and selects the division. When it holds a code that is not a capture code, the event counter is held at zero, so a full count follows every re-enable. When it moves directly from one capture code to another, the counter keeps its value. The first event after such a move may therefore come from a partial count. To avoid that, software first writes a non-capture code and then the new capture code.

The timer is driven from the same clock as this block. The timer itself and the interrupt controller are outside the block.

Top module: `cap_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `cap_o` is 0 and `flag_o` is 0.
- R2: With mode code 4'b0100, every falling transition of the pin causes a capture, and rising transitions cause none.
- R3: With mode code 4'b0101, every rising transition of the pin causes a capture, and falling transitions cause none.
- R4: With mode code 4'b0110, a capture occurs on every fourth rising transition, counted from the moment the mode was enabled.
- R5: With mode code 4'b0111, a capture occurs on every sixteenth rising transition, counted from the moment the mode was enabled.
- R6: Every mode code other than 4'b0100 to 4'b0111 disables capture. Pin transitions then leave `cap_o` and `flag_o` unchanged, and the event counter is cleared, so a divided mode enabled afterwards needs its full number of transitions.
- R7: A direct change between two capture codes keeps the event count. After five rising transitions in 4'b0111 followed by a change to 4'b0110, the very next rising transition causes a capture.
- R8: Suppose a pin transition is present at the pin input at clock edge E0 and completes an event. Then `cap_o` takes, at edge E3, the value `tmr_i` held during the cycle that ends at E3. `flag_o` rises at the same edge.
- R9: `flag_o` stays high until `flag_clr_i` is sampled high in a cycle with no new event. It reads 0 after that edge.
- R10: If an event and `flag_clr_i` fall on the same clock edge, `flag_o` is set, not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; the timer runs on it as well |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin_i | input | 1 | External capture input (asynchronous to the logic) |
| tmr_i | input | 16 | Current timer value |
| mode_i | input | 4 | Capture mode: 0100 fall, 0101 rise, 0110 rise/4, 0111 rise/16, others off |
| flag_clr_i | input | 1 | One-cycle strobe that clears the interrupt flag |
| cap_o | output | 16 | Captured timer value |
| flag_o | output | 1 | Sticky capture interrupt flag |

## Verification
The assertions take for granted that the timer input is synchronous to the module clock. Because of that, the value sampled on an event edge is the value that belongs to that cycle. They also take for granted that the pin is low when reset is released, so that no transition is seen out of reset. The bench drives the pin, the mode and the clear strobe just after falling clock edges and advances the timer on falling edges. It starts with the pin low, and it holds each pin level for at least three cycles. Every transition then reaches the edge detector as one clean step.

// File: rtl/capu_pkg.sv
package capu_pkg;
  localparam int MODE_W = 4;
  localparam int PS_W   = 4;

  typedef struct packed {
    logic            en;
    logic            falling;
    logic [PS_W-1:0] lim;
  } mode_dec_t;

  // Mode codes: 0100 falling, 0101 rising, 0110 rising/4, 0111 rising/16.
  function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] m);
    mode_dec_t d;
    d = '0;
    case (m)
      4'b0100: begin d.en = 1'b1; d.falling = 1'b1; d.lim = 4'd0;  end
      4'b0101: begin d.en = 1'b1; d.lim = 4'd0;  end
      4'b0110: begin d.en = 1'b1; d.lim = 4'd3;  end
      4'b0111: begin d.en = 1'b1; d.lim = 4'd15; end
      default: d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/capu_sync.sv
module capu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= 1'b0;
        else if (g == 0) stg[g] <= d_i;
        else stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/capu_edge.sv
module capu_edge (
  input  logic clk,
  input  logic rst,
  input  logic s_i,
  input  logic falling_i,
  output logic edge_o
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= s_i;
  end

  always_comb begin
    if (falling_i) edge_o = prev & ~s_i;
    else           edge_o = s_i & ~prev;
  end
endmodule

// File: rtl/capu_prescale.sv
module capu_prescale
  import capu_pkg::*;
#(
  parameter int W = PS_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] lim_i,
  input  logic         edge_i,
  output logic         fire_q_o
);
  logic [W-1:0] cnt;
  logic         fire;

  // A count at or above the limit fires on the next edge (partial count after a switch).
  assign fire = en_i && edge_i && (cnt >= lim_i);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      cnt      <= '0;
      fire_q_o <= 1'b0;
    end else begin
      fire_q_o <= fire;
      if (edge_i) begin
        if (fire) cnt <= '0;
        else      cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en_i && !edge_i && $past(en_i)) |=> $stable(cnt) || !en_i); // R7

  AST_OFF_NO_EVENT: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !fire_q_o); // R6
endmodule

// File: rtl/capu_latch.sv
module capu_latch #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [TMR_W-1:0] tmr_i,
  input  logic             clr_i,
  output logic [TMR_W-1:0] cap_o,
  output logic             flag_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (load_i) cap_o <= tmr_i;
      if (load_i)     flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end

  AST_CAP_TAKES_TIMER: assert property (@(posedge clk) disable iff (rst)
    load_i |=> cap_o == $past(tmr_i)); // R8

  AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(cap_o)); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o); // R9

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (load_i && clr_i) |=> flag_o); // R10

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (!load_i && clr_i) |=> !flag_o); // R9
endmodule

// File: rtl/cap_unit.sv
module cap_unit
  import capu_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_pin_i,
  input  logic [TMR_W-1:0]  tmr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              flag_clr_i,
  output logic [TMR_W-1:0]  cap_o,
  output logic              flag_o
);
  mode_dec_t dec;
  logic      pin_s;
  logic      edge_sel;
  logic      fire_q;

  assign dec = decode_mode(mode_i);

  capu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(cap_pin_i), .q_o(pin_s)
  );

  capu_edge u_edge (
    .clk(clk), .rst(rst), .s_i(pin_s), .falling_i(dec.falling), .edge_o(edge_sel)
  );

  capu_prescale #(.W(PS_W)) u_ps (
    .clk(clk), .rst(rst), .en_i(dec.en), .lim_i(dec.lim),
    .edge_i(edge_sel), .fire_q_o(fire_q)
  );

  capu_latch #(.TMR_W(TMR_W)) u_latch (
    .clk(clk), .rst(rst), .load_i(fire_q), .tmr_i(tmr_i),
    .clr_i(flag_clr_i), .cap_o(cap_o), .flag_o(flag_o)
  );

  AST_EVENT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    fire_q |-> $past(edge_sel) && $past(dec.en)); // R3

  AST_RESET_CLEAN: assert property (@(posedge clk)
    $past(rst) |-> (cap_o == '0) && !flag_o); // R1
endmodule

// File: tb/cap_unit_test.sv
module cap_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin = 1'b0;
  logic [15:0] tmr = 16'h1000;
  logic [3:0]  mode = 4'b0000;
  logic        clr = 1'b0;
  logic [15:0] cap;
  logic        flag;

  int checks = 0;
  int fails  = 0;
  logic [15:0] last_cap = 16'h0;
  logic [15:0] t0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(negedge clk) tmr <= tmr + 16'd3;

  cap_unit uut (
    .clk(clk), .rst(rst), .cap_pin_i(pin), .tmr_i(tmr), .mode_i(mode),
    .flag_clr_i(clr), .cap_o(cap), .flag_o(flag)
  );

  // {mode, pin level, capture expected}
  localparam logic [5:0] VEC [12] = '{
    {4'b0101, 1'b1, 1'b1}, {4'b0101, 1'b0, 1'b0}, {4'b0101, 1'b1, 1'b1},
    {4'b0100, 1'b0, 1'b1}, {4'b0100, 1'b1, 1'b0}, {4'b0100, 1'b0, 1'b1},
    {4'b0000, 1'b1, 1'b0}, {4'b0000, 1'b0, 1'b0}, {4'b0011, 1'b1, 1'b0},
    {4'b1000, 1'b0, 1'b0}, {4'b0101, 1'b1, 1'b1}, {4'b1111, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); #1;
    pin = v;
    t0 = tmr;
  endtask

  task automatic clear_flag();
    @(negedge clk); #1; clr = 1'b1;
    @(negedge clk); #1; clr = 1'b0;
  endtask

  // Rising pulse; checks flag after the rise reaches the latch.
  task automatic pulse(input bit exp, input string req);
    set_pin(1'b1);
    step(4);
    chk(flag == exp, req, flag, exp);
    if (exp) begin
      chk(cap == t0 + 16'd9, req, cap, t0 + 16'd9);
      last_cap = cap;
      clear_flag();
    end
    set_pin(1'b0);
    step(3);
  endtask

  initial begin
    step(3);
    chk(cap == 16'h0 && flag == 1'b0, "R1", {cap, flag}, 0);
    @(negedge clk); #1; rst = 1'b0;
    step(1);
    chk(cap == 16'h0 && flag == 1'b0, "R1", {cap, flag}, 0);

    for (int v = 0; v < 12; v++) begin
      @(negedge clk); #1;
      mode = VEC[v][5:2];
      pin  = VEC[v][1];
      t0   = tmr;
      step(4);
      chk(flag == VEC[v][0], "R2/R3/R6 flag", flag, VEC[v][0]);
      if (VEC[v][0]) begin
        chk(cap == t0 + 16'd9, "R8 capture value", cap, t0 + 16'd9);
        last_cap = cap;
      end else begin
        chk(cap == last_cap, "R6 capture held", cap, last_cap);
      end
      clear_flag();
      step(2);
    end

    // R4: divide by four from a cleared count
    mode = 4'b0000; step(2);
    mode = 4'b0110;
    for (int k = 1; k <= 8; k++) pulse(k % 4 == 0, "R4");

    // R5: divide by sixteen
    mode = 4'b0000; step(2);
    mode = 4'b0111;
    for (int k = 1; k <= 16; k++) pulse(k == 16, "R5");

    // R6: disabling clears the partial count
    mode = 4'b0110;
    pulse(1'b0, "R6"); pulse(1'b0, "R6");
    mode = 4'b1010; step(3);
    chk(cap == last_cap, "R6 held while off", cap, last_cap);
    mode = 4'b0110;
    pulse(1'b0, "R6"); pulse(1'b0, "R6"); pulse(1'b0, "R6");
    pulse(1'b1, "R6");

    // R7: direct switch keeps the count
    mode = 4'b0000; step(2);
    mode = 4'b0111;
    for (int k = 0; k < 5; k++) pulse(1'b0, "R7");
    mode = 4'b0110;
    pulse(1'b1, "R7");

    // R9: sticky flag
    mode = 4'b0101;
    set_pin(1'b1);
    step(12);
    chk(flag == 1'b1, "R9 sticky", flag, 1);
    clear_flag();
    step(1);
    chk(flag == 1'b0, "R9 cleared", flag, 0);
    set_pin(1'b0); step(3);

    // R10: set and clear on the same edge
    set_pin(1'b1);
    step(3);
    clr = 1'b1;
    step(1);
    chk(flag == 1'b1, "R10 set wins", flag, 1);
    clr = 1'b0;
    step(1);
    chk(flag == 1'b1, "R10 stays", flag, 1);
    clear_flag();
    step(1);
    chk(flag == 1'b0, "R9 cleared after collision", flag, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule